// File: doc/BRIEF.md
# Comparator Event Interrupt Controller

This block converts a one-bit comparator result, already synchronized to the local clock, into a maskable interrupt. A two-bit event mode selects which transitions of the comparator result set a sticky event flag: any change, only falling transitions, only rising transitions, or nothing. The flag stays set until one of two things clears it. Software can write a one to the flag position, or the interrupt controller can pulse its acknowledge when it takes the vector.

A single control register holds the event mode, the interrupt enable and a routing enable. The routing enable passes the comparator result on to a timer's input-capture trigger. The interrupt request is the flag gated by the local enable and by the processor's global interrupt enable. Transitions are found by comparing the present input with a registered copy from the previous clock. That copy is loaded from the live input in the first cycle after reset, so releasing reset never produces a false edge.

Top module: `cmp_evt_irq`

## Requirements
- R1: After reset, regRdData reads 0x00, irqReq is 0 and capTrig is 0.
- R2: Register layout: bit 0 is the interrupt enable, bit 1 the capture-routing enable, bits 5:4 the event mode, bit 7 the event flag; bits 2, 3 and 6 read as zero. A write with regWrEn high loads bits 0, 1, 5 and 4 from regWrData.
- R3: Event mode 00 sets the flag on any change of cmpIn, mode 10 on a 1-to-0 change and mode 11 on a 0-to-1 change. The flag reads as one after the first rising clock edge that samples the changed input.
- R4: In event mode 01, no change of cmpIn sets the flag.
- R5: A register write with regWrData[7]=1 clears the flag. A write with regWrData[7]=0 leaves the flag unchanged.
- R6: A one-cycle pulse on vecAck clears the flag.
- R7: When a selected event and a clear (a write-one or vecAck) fall in the same cycle, the flag ends up set.
- R8: irqReq is 1 exactly when the flag, the interrupt enable (bit 0) and globalIntEn are all 1.
- R9: capTrig equals cmpIn while the capture-routing enable (bit 1) is 1, and is 0 while that bit is 0.
- R10: A cmpIn level that is held steady across reset release does not set the flag, even though the mode after reset (00) responds to any change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmpIn | input | 1 | Synchronized comparator result |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write data |
| regRdData | output | 8 | Control register read data |
| globalIntEn | input | 1 | Processor global interrupt enable |
| vecAck | input | 1 | Interrupt vector taken, clears flag |
| irqReq | output | 1 | Interrupt request |
| capTrig | output | 1 | Trigger to timer input capture |

## Verification
Faults in the stored previous sample appear at bit 7 of the read data one edge after the faulty compare. A stale sample shows up as a flag that never rises, and a sample that never loads shows up as a flag set without cause. Mode decode errors surface in the sweep of every mode against every input transition, one cycle after each change. A wrong clear priority shows up in the cycle that follows a coincident event and acknowledge. A wrong gating term shows up at once on irqReq or capTrig, because both are combinational from the register state.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;
  localparam int IRQEN_BIT = 0;
  localparam int CAPEN_BIT = 1;
  localparam int MODE_LSB  = 4;
  localparam int MODE_W    = 2;
  localparam int FLAG_BIT  = 7;
  localparam int REG_MIN_W = FLAG_BIT + 1;

  typedef enum logic [MODE_W-1:0] {
    MODE_ANY  = 2'b00,
    MODE_NONE = 2'b01,
    MODE_FALL = 2'b10,
    MODE_RISE = 2'b11
  } evtMode_e;

  typedef struct packed {
    logic setFlag;
    logic clrFlag;
    logic wrCtrl;
  } strobe_t;
endpackage

// File: rtl/cmp_irq_ctrl.sv
module cmp_irq_ctrl
  import cmp_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmpIn,
  input  evtMode_e mode,
  input  logic     regWrEn,
  input  logic     wrFlagOne,
  input  logic     vecAck,
  output strobe_t  strobes
);
  logic prevSample;
  logic primed;
  logic riseSeen;
  logic fallSeen;
  logic evtHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSample <= 1'b0;
      primed     <= 1'b0;
    end else begin
      prevSample <= cmpIn;
      primed     <= 1'b1;
    end
  end

  always_comb begin
    riseSeen = primed && cmpIn && !prevSample;
    fallSeen = primed && !cmpIn && prevSample;
    unique case (mode)
      MODE_ANY:  evtHit = riseSeen || fallSeen;
      MODE_FALL: evtHit = fallSeen;
      MODE_RISE: evtHit = riseSeen;
      default:   evtHit = 1'b0;
    endcase
    strobes.setFlag = evtHit;
    strobes.clrFlag = vecAck || (regWrEn && wrFlagOne);
    strobes.wrCtrl  = regWrEn;
  end
endmodule

// File: rtl/cmp_irq_regs.sv
module cmp_irq_regs
  import cmp_irq_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [REG_W-1:0] regWrData,
  input  logic             cmpIn,
  input  logic             globalIntEn,
  output evtMode_e         mode,
  output logic [REG_W-1:0] regRdData,
  output logic             irqReq,
  output logic             capTrig
);
  logic irqEn;
  logic capEn;
  logic flag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEn <= 1'b0;
      capEn <= 1'b0;
      mode  <= MODE_ANY;
    end else if (strobes.wrCtrl) begin
      irqEn <= regWrData[IRQEN_BIT];
      capEn <= regWrData[CAPEN_BIT];
      mode  <= evtMode_e'(regWrData[MODE_LSB +: MODE_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                flag <= 1'b0;
    else if (strobes.setFlag) flag <= 1'b1;
    else if (strobes.clrFlag) flag <= 1'b0;
  end

  always_comb begin
    regRdData                        = '0;
    regRdData[IRQEN_BIT]             = irqEn;
    regRdData[CAPEN_BIT]             = capEn;
    regRdData[MODE_LSB +: MODE_W]    = mode;
    regRdData[FLAG_BIT]              = flag;
  end

  assign irqReq  = flag && irqEn && globalIntEn;
  assign capTrig = capEn && cmpIn;
endmodule

// File: rtl/cmp_evt_irq.sv
module cmp_evt_irq
  import cmp_irq_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmpIn,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             globalIntEn,
  input  logic             vecAck,
  output logic             irqReq,
  output logic             capTrig
);
  strobe_t  strobes;
  evtMode_e mode;

  cmp_irq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmpIn     (cmpIn),
    .mode      (mode),
    .regWrEn   (regWrEn),
    .wrFlagOne (regWrData[FLAG_BIT]),
    .vecAck    (vecAck),
    .strobes   (strobes)
  );

  cmp_irq_regs #(.REG_W(REG_W)) u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .regWrData   (regWrData),
    .cmpIn       (cmpIn),
    .globalIntEn (globalIntEn),
    .mode        (mode),
    .regRdData   (regRdData),
    .irqReq      (irqReq),
    .capTrig     (capTrig)
  );
endmodule

// File: rtl/cmp_evt_irq_chk.sv
module cmp_evt_irq_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmpIn,
  input logic             regWrEn,
  input logic [REG_W-1:0] regWrData,
  input logic [REG_W-1:0] regRdData,
  input logic             globalIntEn,
  input logic             vecAck,
  input logic             irqReq,
  input logic             capTrig
);
  logic flagQ;
  logic [1:0] modeQ;
  assign flagQ = regRdData[7];
  assign modeQ = regRdData[5:4];

  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rstN)
    irqReq == (flagQ && regRdData[0] && globalIntEn));

  a_r9_cap_route: assert property (@(posedge clk) disable iff (!rstN)
    capTrig == (cmpIn && regRdData[1]));

  a_r4_reserved_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 2'b01 && !flagQ) |=> !flagQ);

  a_r3_any_edge_sets: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && modeQ == 2'b00 && cmpIn != $past(cmpIn)) |=> flagQ);

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (vecAck && cmpIn == $past(cmpIn) && !regWrEn) |=> !flagQ);

  a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrData[7] && cmpIn == $past(cmpIn)) |=> !flagQ);

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && vecAck && modeQ == 2'b00 && cmpIn != $past(cmpIn)) |=> flagQ);
endmodule

bind cmp_evt_irq cmp_evt_irq_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/cmp_evt_irq_bench.sv
module cmp_evt_irq_bench;
  logic       clk = 1'b0;
  logic       rstN;
  logic       cmpIn;
  logic       regWrEn;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic       globalIntEn;
  logic       vecAck;
  logic       irqReq;
  logic       capTrig;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cmp_evt_irq u_cmp_evt_irq (
    .clk(clk), .rstN(rstN), .cmpIn(cmpIn), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .globalIntEn(globalIntEn),
    .vecAck(vecAck), .irqReq(irqReq), .capTrig(capTrig)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    regWrEn = 1'b1;
    regWrData = d;
    tick();
    regWrEn = 1'b0;
    regWrData = 8'h00;
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit expSet(input int m, input bit a, input bit b);
    if (a == b) return 1'b0;
    case (m)
      0: return 1'b1;
      2: return a && !b;
      3: return !a && b;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #100000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cmpIn = 1'b1; regWrEn = 1'b0; regWrData = 8'h00;
    globalIntEn = 1'b0; vecAck = 1'b0;
    @(negedge clk); tick(); tick();
    // R1 reset state
    check("R1 regRdData", regRdData, 8'h00);
    check("R1 irqReq", irqReq, 0);
    check("R1 capTrig", capTrig, 0);
    // R10 steady high input across reset release, mode 00
    rstN = 1'b1;
    tick(); tick(); tick();
    check("R10 no spurious flag", regRdData[7], 0);

    // R2 layout readback (bit 7 and unused bits not stored)
    wr(8'hFF);
    check("R2 readback", regRdData, 8'h33);
    wr(8'h00);

    // R3/R4 sweep of every mode and transition
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 2; a++) begin
        for (int b = 0; b < 2; b++) begin
          cmpIn = a[0];
          tick(); tick();
          wr(8'h80 | 8'(m << 4));
          check(m == 1 ? "R4 cleared before" : "R3 cleared before", regRdData[7], 0);
          cmpIn = b[0];
          tick();
          check(m == 1 ? "R4 reserved mode" : "R3 mode event", regRdData[7], expSet(m, a[0], b[0]));
        end
      end
    end

    // R5 write-one-to-clear and write-zero-keeps
    cmpIn = 1'b0; wr(8'h80); tick();
    cmpIn = 1'b1; tick();
    check("R5 flag set", regRdData[7], 1);
    wr(8'h00);
    check("R5 write zero keeps", regRdData[7], 1);
    wr(8'h80);
    check("R5 write one clears", regRdData[7], 0);

    // R6 vector acknowledge clears
    cmpIn = 1'b0; tick();
    check("R6 flag set", regRdData[7], 1);
    vecAck = 1'b1; tick(); vecAck = 1'b0;
    check("R6 ack clears", regRdData[7], 0);

    // R7 set wins over ack and over write-one
    cmpIn = 1'b1; vecAck = 1'b1; tick(); vecAck = 1'b0;
    check("R7 set beats ack", regRdData[7], 1);
    cmpIn = 1'b0; wr(8'h80);
    check("R7 set beats w1c", regRdData[7], 1);

    // R8 gating sweep: flag x irqEn x globalIntEn
    for (int f = 0; f < 2; f++) begin
      for (int e = 0; e < 2; e++) begin
        for (int g = 0; g < 2; g++) begin
          wr(8'h80);
          if (f != 0) begin cmpIn = ~cmpIn; tick(); end
          wr(8'(e));
          globalIntEn = g[0];
          #1;
          check("R8 irqReq", irqReq, f & e & g);
        end
      end
    end
    globalIntEn = 1'b0;

    // R9 capture routing
    wr(8'h02);
    cmpIn = 1'b1; #1; check("R9 routed high", capTrig, 1);
    cmpIn = 1'b0; #1; check("R9 routed low", capTrig, 0);
    wr(8'h00);
    cmpIn = 1'b1; #1; check("R9 blocked", capTrig, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule